// File: doc/BRIEF.md
# General-Purpose Pin Controller with Sticky Interrupts

This block controls a bank of general-purpose pins through a small word-addressed register bus. Each pin has its own settings: input sensing, output drive enable, output level, pull-up and drive strength. Every register holds one bit per pin, and no pin's settings affect another pin. A per-pin override hands the pad's output level and output enable to one of two on-chip peripheral sources. A per-pin polarity flip is applied to the pad level last, after that choice is made.

Pad inputs pass through a two-stage synchronizer and are then masked by the sense enable. The masked level feeds four detectors per pin: rising change, falling change, level high and level low. Each detector sets its own sticky flag. Software clears a flag by writing a 1 to it. Each flag class has its own arm register. A pin's interrupt line is high while any armed class has its flag set for that pin.

Top module: `gpio_ctrl`

## Requirements
- R1: While reset is asserted and on release, every register is zero: pad_oe, pad_out and irq are 0, and every register reads 0, flags included.
- R2: Byte addresses (bit n of each register belongs to pin n): 0x00 masked input level (read-only), 0x04 sense enable, 0x08 drive enable, 0x0C drive level, 0x10 pull-up, 0x14 strength, 0x38 override enable, 0x3C override source pick, 0x40 polarity flip; arm/flag pairs: rising 0x18/0x1C, falling 0x20/0x24, high 0x28/0x2C, low 0x30/0x34.
- R3: Reading 0x00 returns the pad input ANDed with the sense enable. A pad change becomes visible in this read after the second rising clock edge. Writes to 0x00 have no effect.
- R4: When override is off, pad_oe and pad_out follow the drive enable and drive level registers. pad_ie, pad_pue and pad_ds always mirror the sense, pull-up and strength registers. A register write takes effect at the ports right after the edge that accepts it.
- R5: When a pin's override enable bit is 1, that pin's pad_out and pad_oe come from source 1 if its pick bit is 1, and from source 0 if the pick bit is 0.
- R6: The polarity flip bit is XORed into pad_out after the override choice. It does not affect pad_oe.
- R7: A low-to-high change of the masked level sets the rising flag. The flag reads back after the third rising edge following the pad change.
- R8: A high-to-low change of the masked level sets the falling flag, with the same latency as R7.
- R9: The high flag is set on every cycle the masked level is 1, and the low flag on every cycle it is 0. A level flag cleared while its condition holds stays set.
- R10: A set flag stays set until a 1 is written to its bit at the flag address. Writing 0, or writing 1 to other bits, leaves it set.
- R11: If a clearing write and a new event for the same flag bit land on the same edge, the bit stays set. Other bits covered by the same write are cleared.
- R12: irq[n] is 1 exactly when, for some class, both the flag bit and the arm bit of pin n are set.
- R13: Reads from unmapped or misaligned addresses return 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 7 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, accepted at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| pad_in | input | NPIN | Raw pad input levels, asynchronous |
| pad_ie | output | NPIN | Pad input-buffer enable |
| pad_oe | output | NPIN | Pad output enable |
| pad_out | output | NPIN | Pad output level |
| pad_pue | output | NPIN | Pad pull-up enable |
| pad_ds | output | NPIN | Pad drive-strength select |
| fn0_out | input | NPIN | Peripheral source 0 output level |
| fn0_oe | input | NPIN | Peripheral source 0 output enable |
| fn1_out | input | NPIN | Peripheral source 1 output level |
| fn1_oe | input | NPIN | Peripheral source 1 output enable |
| irq | output | NPIN | Per-pin interrupt request |

## Verification
The flag properties assume that a flag changes only through its detector or through a write to its own flag address. They also assume that bus_we and bus_addr carry known values whenever the internal reset is released. The stimulus keeps to this: it defines every input from time zero and changes inputs only on the falling clock edge. bus_we is raised for exactly one edge per write. Pad levels are held steady long enough for the two synchronizer stages and the detector stage to settle before a flag is read. The one exception is the collision scenario, where a clearing write is placed deliberately on the edge at which the detector fires.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int ADDR_W = 7;
  localparam int BUS_W  = 32;
  localparam int NCLS   = 4;
  localparam int NCFG   = 12;

  // Interrupt class order fixes the arm/flag address pairing.
  typedef enum logic [1:0] {
    EV_UP = 2'd0,
    EV_DN = 2'd1,
    EV_HI = 2'd2,
    EV_LO = 2'd3
  } ev_cls_e;

  // Writable configuration words; the four arm words are contiguous.
  typedef enum logic [3:0] {
    CF_SENSE    = 4'd0,
    CF_DRV_EN   = 4'd1,
    CF_DRV_VAL  = 4'd2,
    CF_PULL     = 4'd3,
    CF_STRENGTH = 4'd4,
    CF_ARM_UP   = 4'd5,
    CF_ARM_DN   = 4'd6,
    CF_ARM_HI   = 4'd7,
    CF_ARM_LO   = 4'd8,
    CF_ALT_EN   = 4'd9,
    CF_ALT_PICK = 4'd10,
    CF_FLIP     = 4'd11
  } cfg_idx_e;

  localparam logic [ADDR_W-1:0] A_LEVEL = 7'h00;

  function automatic logic [ADDR_W-1:0] cfg_addr(input int idx);
    logic [ADDR_W-1:0] a;
    case (idx)
      0:       a = 7'h04;
      1:       a = 7'h08;
      2:       a = 7'h0C;
      3:       a = 7'h10;
      4:       a = 7'h14;
      5:       a = 7'h18;
      6:       a = 7'h20;
      7:       a = 7'h28;
      8:       a = 7'h30;
      9:       a = 7'h38;
      10:      a = 7'h3C;
      11:      a = 7'h40;
      default: a = 7'h7F;
    endcase
    return a;
  endfunction

  function automatic logic [ADDR_W-1:0] flag_addr(input int cls);
    logic [ADDR_W-1:0] a;
    case (cls)
      0:       a = 7'h1C;
      1:       a = 7'h24;
      2:       a = 7'h2C;
      3:       a = 7'h34;
      default: a = 7'h7F;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       we,
  input  logic [NPIN-1:0]            wbits,
  output logic [NCFG-1:0][NPIN-1:0]  cfg_q
);

  logic [NCFG-1:0]            hit;
  logic [NCFG-1:0][NPIN-1:0]  cfg_d;

  for (genvar i = 0; i < NCFG; i++) begin : g_dec
    assign hit[i] = we && (addr == cfg_addr(i));
  end

  always_comb begin
    for (int i = 0; i < NCFG; i++) begin
      cfg_d[i] = hit[i] ? wbits : cfg_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPIN-1:0]            lvl,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       we,
  input  logic [NPIN-1:0]            wbits,
  input  logic [NCLS-1:0][NPIN-1:0]  arm,
  output logic [NCLS-1:0][NPIN-1:0]  flag_q,
  output logic [NPIN-1:0]            irq
);

  logic [NPIN-1:0]            lvl_prev;
  logic [NCLS-1:0][NPIN-1:0]  evt;
  logic [NCLS-1:0][NPIN-1:0]  clr;
  logic [NCLS-1:0][NPIN-1:0]  flag_d;

  always_comb begin
    evt[EV_UP] = lvl & ~lvl_prev;
    evt[EV_DN] = ~lvl & lvl_prev;
    evt[EV_HI] = lvl;
    evt[EV_LO] = ~lvl;
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    assign clr[c] = (we && (addr == flag_addr(c))) ? wbits : '0;
    // A fresh event outranks a clear landing on the same edge.
    assign flag_d[c] = (flag_q[c] & ~clr[c]) | evt[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev <= '0;
      flag_q   <= '0;
    end else begin
      lvl_prev <= lvl;
      flag_q   <= flag_d;
    end
  end

  always_comb begin
    irq = '0;
    for (int c = 0; c < NCLS; c++) begin
      irq = irq | (flag_q[c] & arm[c]);
    end
  end

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int NPIN = 32
) (
  input  logic [NPIN-1:0] drv_en,
  input  logic [NPIN-1:0] drv_val,
  input  logic [NPIN-1:0] alt_en,
  input  logic [NPIN-1:0] alt_pick,
  input  logic [NPIN-1:0] flip,
  input  logic [NPIN-1:0] fn0_out,
  input  logic [NPIN-1:0] fn0_oe,
  input  logic [NPIN-1:0] fn1_out,
  input  logic [NPIN-1:0] fn1_oe,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe
);

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic src_val;
    logic src_oe;
    always_comb begin
      if (alt_en[p]) begin
        src_val = alt_pick[p] ? fn1_out[p] : fn0_out[p];
        src_oe  = alt_pick[p] ? fn1_oe[p]  : fn0_oe[p];
      end else begin
        src_val = drv_val[p];
        src_oe  = drv_en[p];
      end
    end
    assign pad_out[p] = src_val ^ flip[p];
    assign pad_oe[p]  = src_oe;
  end

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [NPIN-1:0]    pad_in,
  output logic [NPIN-1:0]    pad_ie,
  output logic [NPIN-1:0]    pad_oe,
  output logic [NPIN-1:0]    pad_out,
  output logic [NPIN-1:0]    pad_pue,
  output logic [NPIN-1:0]    pad_ds,
  input  logic [NPIN-1:0]    fn0_out,
  input  logic [NPIN-1:0]    fn0_oe,
  input  logic [NPIN-1:0]    fn1_out,
  input  logic [NPIN-1:0]    fn1_oe,
  output logic [NPIN-1:0]    irq
);

  logic                       core_rst_n;
  logic [NPIN-1:0]            wbits;
  logic [NPIN-1:0]            pin_sync;
  logic [NPIN-1:0]            pin_lvl;
  logic [NCFG-1:0][NPIN-1:0]  cfg_q;
  logic [NCLS-1:0][NPIN-1:0]  flag_vec;
  logic [NPIN-1:0]            rd_bits;

  gpio_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (core_rst_n)
  );

  gpio_sync #(.W(NPIN), .STAGES(2)) u_in_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  assign wbits   = bus_wdata[NPIN-1:0];
  assign pin_lvl = pin_sync & cfg_q[CF_SENSE];

  gpio_regfile #(.NPIN(NPIN)) u_regs (
    .clk   (clk),
    .rst_n (core_rst_n),
    .addr  (bus_addr),
    .we    (bus_we),
    .wbits (wbits),
    .cfg_q (cfg_q)
  );

  gpio_irq_bank #(.NPIN(NPIN)) u_irq (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .lvl    (pin_lvl),
    .addr   (bus_addr),
    .we     (bus_we),
    .wbits  (wbits),
    .arm    (cfg_q[int'(CF_ARM_UP) +: NCLS]),
    .flag_q (flag_vec),
    .irq    (irq)
  );

  gpio_pad_mux #(.NPIN(NPIN)) u_mux (
    .drv_en   (cfg_q[CF_DRV_EN]),
    .drv_val  (cfg_q[CF_DRV_VAL]),
    .alt_en   (cfg_q[CF_ALT_EN]),
    .alt_pick (cfg_q[CF_ALT_PICK]),
    .flip     (cfg_q[CF_FLIP]),
    .fn0_out  (fn0_out),
    .fn0_oe   (fn0_oe),
    .fn1_out  (fn1_out),
    .fn1_oe   (fn1_oe),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  assign pad_ie  = cfg_q[CF_SENSE];
  assign pad_pue = cfg_q[CF_PULL];
  assign pad_ds  = cfg_q[CF_STRENGTH];

  always_comb begin
    rd_bits = '0;
    if (bus_addr == A_LEVEL) begin
      rd_bits = pin_lvl;
    end
    for (int i = 0; i < NCFG; i++) begin
      if (bus_addr == cfg_addr(i)) begin
        rd_bits = cfg_q[i];
      end
    end
    for (int c = 0; c < NCLS; c++) begin
      if (bus_addr == flag_addr(c)) begin
        rd_bits = flag_vec[c];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    bus_rdata[NPIN-1:0] = rd_bits;
  end

endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NPIN = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       core_rst_n,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_we,
  input logic [BUS_W-1:0]           bus_wdata,
  input logic [BUS_W-1:0]           bus_rdata,
  input logic [NPIN-1:0]            pad_oe,
  input logic [NPIN-1:0]            pad_out,
  input logic [NPIN-1:0]            irq,
  input logic [NPIN-1:0]            pin_lvl,
  input logic [NCLS-1:0][NPIN-1:0]  flag_vec
);

  // R1: internal reset leaves outputs quiet and no flag set
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_n) |-> (irq == '0 && pad_oe == '0 && pad_out == '0 && flag_vec == '0));

  // R10: bits survive unless written 1 at their own flag address
  for (genvar c = 0; c < NCLS; c++) begin : g_sticky
    logic [NPIN-1:0] clr_m;
    assign clr_m = (bus_we && bus_addr == flag_addr(c)) ? bus_wdata[NPIN-1:0] : '0;
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
      1'b1 |=> ((flag_vec[c] & $past(flag_vec[c] & ~clr_m)) == $past(flag_vec[c] & ~clr_m)));
  end

  // R7: rising change of the masked level raises the rising flag
  p_rise_sets_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    1'b1 |=> ((flag_vec[EV_UP] & ($past(pin_lvl) & ~$past(pin_lvl, 2)))
              == ($past(pin_lvl) & ~$past(pin_lvl, 2))));

  // R8: falling change raises the falling flag
  p_fall_sets_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    1'b1 |=> ((flag_vec[EV_DN] & (~$past(pin_lvl) & $past(pin_lvl, 2)))
              == (~$past(pin_lvl) & $past(pin_lvl, 2))));

  // R9: level flags track the level they watch
  p_level_sets_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    1'b1 |=> (((flag_vec[EV_HI] & $past(pin_lvl)) == $past(pin_lvl)) &&
              ((flag_vec[EV_LO] & ~$past(pin_lvl)) == ~$past(pin_lvl))));

  // R12: no request without some pending flag on that pin
  p_irq_needs_flag_r12: assert property (@(posedge clk) disable iff (!core_rst_n)
    (irq & ~(flag_vec[0] | flag_vec[1] | flag_vec[2] | flag_vec[3])) == '0);

  // R13: holes in the map read as zero
  p_hole_reads_zero_r13: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_addr > 7'h40 || bus_addr[1:0] != 2'b00) |-> bus_rdata == '0);

endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NPIN(NPIN)) u_chk (.*);

// File: tb/tb_gpio_ctrl.sv
module tb_gpio_ctrl;

  localparam int NP = 32;
  localparam logic [6:0] O_LVL = 7'h00, O_SNS = 7'h04, O_OE = 7'h08, O_OUT = 7'h0C;
  localparam logic [6:0] O_PU = 7'h10, O_DS = 7'h14;
  localparam logic [6:0] O_AUP = 7'h18, O_FUP = 7'h1C, O_ADN = 7'h20, O_FDN = 7'h24;
  localparam logic [6:0] O_AHI = 7'h28, O_FHI = 7'h2C, O_ALO = 7'h30, O_FLO = 7'h34;
  localparam logic [6:0] O_ALT = 7'h38, O_PICK = 7'h3C, O_FLIP = 7'h40;

  logic          clk;
  logic          rst_n;
  logic [6:0]    bus_addr;
  logic          bus_we;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in, pad_ie, pad_oe, pad_out, pad_pue, pad_ds;
  logic [NP-1:0] fn0_out, fn0_oe, fn1_out, fn1_oe, irq;

  int n_vec = 0;
  int n_bad = 0;

  gpio_ctrl #(.NPIN(NP)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_ie(pad_ie), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pue(pad_pue),
    .pad_ds(pad_ds), .fn0_out(fn0_out), .fn0_oe(fn0_oe), .fn1_out(fn1_out),
    .fn1_oe(fn1_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    settle(3);
    chk("R1 pad_oe in reset", pad_oe, '0);
    chk("R1 pad_out in reset", pad_out, '0);
    chk("R1 irq in reset", irq, '0);
    rd(O_FLO, v); chk("R1 low flag in reset", v, '0);
    rst_n = 1'b1;
    settle(4);
    for (int i = 1; i <= 16; i++) begin
      if (7'(i * 4) != O_FLO) begin
        rd(7'(i * 4), v); chk("R1 register zero after reset", v, '0);
      end
    end
  endtask

  task automatic t_input();
    logic [31:0] v;
    wr(O_SNS, 32'hFFFF_FFFF);
    pad_in = 32'hA5C3_0F96;
    settle(1);
    rd(O_LVL, v); chk("R3 level after one edge", v, '0);
    settle(1);
    rd(O_LVL, v); chk("R3 level after two edges", v, 32'hA5C3_0F96);
    wr(O_SNS, 32'hFFFF_0000);
    rd(O_LVL, v); chk("R3 level masked by sense", v, 32'hA5C3_0000);
    wr(O_LVL, 32'h1234_5678);
    rd(O_LVL, v); chk("R3 write to level ignored", v, 32'hA5C3_0000);
    wr(O_SNS, 32'hFFFF_FFFF);
    pad_in = '0;
    settle(3);
  endtask

  task automatic t_drive();
    logic [31:0] v;
    wr(O_OE, 32'h0F0F_00FF);
    wr(O_OUT, 32'h33CC_55AA);
    wr(O_PU, 32'h0000_FFF0);
    wr(O_DS, 32'h8001_8001);
    chk("R4 pad_oe", pad_oe, 32'h0F0F_00FF);
    chk("R4 pad_out", pad_out, 32'h33CC_55AA);
    chk("R4 pad_pue", pad_pue, 32'h0000_FFF0);
    chk("R4 pad_ds", pad_ds, 32'h8001_8001);
    chk("R4 pad_ie", pad_ie, 32'hFFFF_FFFF);
    rd(O_OUT, v); chk("R2 drive level readback", v, 32'h33CC_55AA);
  endtask

  task automatic t_override();
    logic [31:0] a, p, eo, ee;
    fn0_out = 32'hAAAA_AAAA; fn0_oe = 32'h0000_FFFF;
    fn1_out = 32'h5555_5555; fn1_oe = 32'hFFFF_0000;
    a = 32'h00FF_00FF; p = 32'h0000_FFFF;
    wr(O_ALT, a);
    wr(O_PICK, p);
    eo = (a & p & fn1_out) | (a & ~p & fn0_out) | (~a & 32'h33CC_55AA);
    ee = (a & p & fn1_oe)  | (a & ~p & fn0_oe)  | (~a & 32'h0F0F_00FF);
    chk("R5 override pad_out", pad_out, eo);
    chk("R5 override pad_oe", pad_oe, ee);
    wr(O_FLIP, 32'hF0F0_F0F0);
    chk("R6 flipped pad_out", pad_out, eo ^ 32'hF0F0_F0F0);
    chk("R6 flip leaves pad_oe", pad_oe, ee);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    wr(O_FUP, '1); wr(O_FDN, '1); wr(O_FHI, '1); wr(O_FLO, '1);
    rd(O_FUP, v); chk("R10 rising flags cleared", v, '0);
    pad_in = 32'h0000_0008;
    settle(2);
    rd(O_FUP, v); chk("R7 rising flag not before third edge", v, '0);
    settle(1);
    rd(O_FUP, v); chk("R7 rising flag set", v, 32'h8);
    rd(O_FDN, v); chk("R8 no falling flag on rise", v, '0);
    pad_in = '0;
    settle(3);
    rd(O_FDN, v); chk("R8 falling flag set", v, 32'h8);
    rd(O_FUP, v); chk("R10 rising flag held after drop", v, 32'h8);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    wr(O_FUP, 32'h0);
    rd(O_FUP, v); chk("R10 write zero keeps flag", v, 32'h8);
    wr(O_FUP, 32'h4);
    rd(O_FUP, v); chk("R10 other bit write keeps flag", v, 32'h8);
    wr(O_FUP, 32'h8);
    rd(O_FUP, v); chk("R10 write one clears flag", v, '0);
    wr(O_FDN, '1);
    rd(O_FDN, v); chk("R10 falling flags cleared", v, '0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    pad_in = 32'h0000_0020;
    settle(3);
    wr(O_FHI, '1);
    rd(O_FHI, v); chk("R9 high flag survives clear", v, 32'h20);
    wr(O_FLO, '1);
    rd(O_FLO, v); chk("R9 low flags survive clear", v, ~32'h20);
    pad_in = '0;
    settle(3);
    rd(O_FHI, v); chk("R9 high flag held after drop", v, 32'h20);
    wr(O_FHI, '1);
    rd(O_FHI, v); chk("R9 high flag clears when level gone", v, '0);
    wr(O_FUP, '1); wr(O_FDN, '1);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    pad_in = 32'h0000_0008;
    settle(3);
    rd(O_FUP, v); chk("R7 bit3 pending before collision", v, 32'h8);
    pad_in = 32'h0000_0088;
    settle(2);
    bus_addr = O_FUP; bus_wdata = '1; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(O_FUP, v); chk("R11 event beats clear, old bit cleared", v, 32'h80);
  endtask

  task automatic t_irq();
    chk("R12 no arm no irq", irq, '0);
    wr(O_AUP, 32'h80);
    chk("R12 rising armed", irq, 32'h80);
    wr(O_AUP, 32'h0);
    chk("R12 disarm drops irq", irq, '0);
    wr(O_AHI, '1);
    chk("R12 high armed", irq, 32'h88);
    wr(O_AHI, 32'h0);
    wr(O_ALO, 32'h1);
    chk("R12 low armed", irq, 32'h1);
    wr(O_ALO, 32'h0);
  endtask

  task automatic t_holes();
    logic [31:0] v;
    wr(7'h44, '1);
    wr(7'h7C, '1);
    wr(7'h05, '1);
    rd(7'h44, v); chk("R13 read 0x44", v, '0);
    rd(7'h7C, v); chk("R13 read 0x7C", v, '0);
    rd(7'h06, v); chk("R13 misaligned read", v, '0);
    chk("R13 strength untouched", pad_ds, 32'h8001_8001);
    chk("R13 irq untouched", irq, '0);
    rd(O_PU, v); chk("R13 pull-up untouched", v, 32'h0000_FFF0);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    pad_in = '0; fn0_out = '0; fn0_oe = '0; fn1_out = '0; fn1_oe = '0;
    t_reset();
    t_input();
    t_drive();
    t_override();
    t_edges();
    t_sticky();
    t_level();
    t_collide();
    t_irq();
    t_holes();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule